// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the bus writes sent to a parallel flash with a standard command set. Every accepted write carries an address, a data word and a byte/word width flag. The decoder follows the multi-write unlock protocol and turns each complete, valid sequence into a one-cycle command pulse. A neighbouring program/erase engine acts on that pulse. For program and block-erase commands, the decoder also keeps the address and data that go with the command. It reports whether the array is in plain read, identification, bypass or erase-collection mode. It also supplies the identification word that a read returns in identification mode.

Two busy inputs from the program/erase engine gate the decoder. While a program runs, every write is ignored. While an erase runs, only the suspend and reset writes are recognised. A bypass mode shortens program commands to two writes and rejects everything except the bypass program, the bypass exit and a reset.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The first unlock write is data AA and the second is data 55. In word mode (`byte_mode`=0), the key is `wr_addr[10:0]` and must be 555h for the first write and 2AAh for the second. In byte mode, the key is the 12-bit value {`wr_addr[10:0]`,`wr_lsb`} and must be AAAh for the first write and 555h for the second.
- R2: `wr_addr` bits above bit 10 and `wr_data[15:8]` never affect decoding. `wr_lsb` also has no effect in word mode.
- R3: After the two unlock writes, the third write selects the command. F0 at any address is a reset and leaves mode 0. At the first unlock key, 90 gives mode 1 (identification) and 20 gives mode 2 (bypass). A0 at that key arms a program. 80 at that key arms an erase. Any other third write returns to mode 0 with no pulse.
- R4: After A0 has armed a program, the next write at any address pulses `cmd_program` one cycle after that write. `op_addr` then holds {`wr_addr`, `byte_mode`?`wr_lsb`:0}. `op_data` holds `wr_data` in word mode and {00h,`wr_data[7:0]`} in byte mode.
- R5: After 80, a second AA/55 unlock pair is required. Data 10 at the first unlock key then pulses `cmd_chip_erase`. Data 10 at any other address gives no pulse.
- R6: After 80 and the second unlock pair, data 30 at any address pulses `cmd_block_erase`, latches `op_addr` and enters mode 3. In mode 3, each further 30 adds one more block with its own pulse. Mode 3 ends (to mode 0) on any other write, or in the cycle after `ers_active` is seen high.
- R7: A single write in mode 0 needs no unlock. F0 pulses `cmd_reset`, B0 pulses `cmd_suspend` and 30 pulses `cmd_resume`.
- R8: A write that breaks a sequence returns the decoder to mode 0 with no pulse. The following write is then treated as the start of a new sequence.
- R9: In mode 2, A0 followed by any write pulses `cmd_program` with the address and data of that write. 90 followed by 00 returns to mode 0. All other writes give no pulse and leave mode 2.
- R10: In mode 2, a single F0 pulses `cmd_reset` and the mode stays 2. This also holds while `ers_active` is high.
- R11: `as_data` is combinational in `rd_addr`. `rd_addr[1:0]`=00 gives 0020h and 01 gives the device code (0051h by default). 10 gives 0001h if `prot_map` bit `rd_addr[16:12]` is set and 0000h otherwise. 11 gives 0000h.
- R12: While `pgm_active` is high, writes are ignored: no pulse and no change of mode or sequence.
- R13: While `ers_active` is high (and `pgm_active` low), only F0 (`cmd_reset`; mode 0, or stays 2) and B0 (`cmd_suspend`) are recognised. All other writes are ignored.
- R14: Command pulses rise in the cycle after the clock edge that samples the write. They last one cycle, and at most one is high at a time. After reset, all pulses are low, mode is 0 and `op_addr`/`op_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| wr_en | input | 1 | Bus write valid this cycle (strobe-qualified enable) |
| wr_addr | input | 17 | Write address (word granularity) |
| wr_lsb | input | 1 | Extra low address bit, used in byte mode |
| wr_data | input | 16 | Write data |
| byte_mode | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| pgm_active | input | 1 | Program operation running |
| ers_active | input | 1 | Erase operation running |
| rd_addr | input | 17 | Read address for identification data |
| prot_map | input | 32 | Protection flag per 4K-word sector |
| mode | output | 2 | 0 read, 1 identification, 2 bypass, 3 erase collection |
| cmd_reset | output | 1 | Reset command pulse |
| cmd_suspend | output | 1 | Erase suspend pulse |
| cmd_resume | output | 1 | Erase resume pulse |
| cmd_program | output | 1 | Program command pulse |
| cmd_chip_erase | output | 1 | Chip erase pulse |
| cmd_block_erase | output | 1 | Block erase (or added block) pulse |
| op_addr | output | 18 | Latched program/erase address |
| op_data | output | 16 | Latched program data |
| as_data | output | 16 | Identification read word |

## Verification
Each write goes through one register stage before its result appears. The command pulses, the mode and the latched operand all change at the clock edge that samples the write. The bench drives every write at a falling edge and holds it for exactly one cycle. It then reads the outputs at the next falling edge, which is the only half-cycle in which that write's pulse is high. The mode 3 exit caused by `ers_active` is read one cycle after that input rises. `as_data` is combinational, so it is read one time unit after `rd_addr` changes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_ASEL = 2'd1,
    MODE_BYP  = 2'd2,
    MODE_ECOL = 2'd3
  } mode_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PGM,
    SQ_ERS1,
    SQ_ERS2,
    SQ_ERS3,
    SQ_BPGM,
    SQ_BEXIT
  } seq_e;

  typedef struct packed {
    logic rst;
    logic susp;
    logic resume;
    logic pgm;
    logic chip;
    logic blk;
  } cmd_t;

  localparam logic [7:0] K_UNL_A = 8'hAA;
  localparam logic [7:0] K_UNL_B = 8'h55;
  localparam logic [7:0] K_RESET = 8'hF0;
  localparam logic [7:0] K_ASEL  = 8'h90;
  localparam logic [7:0] K_PGM   = 8'hA0;
  localparam logic [7:0] K_BYP   = 8'h20;
  localparam logic [7:0] K_ERASE = 8'h80;
  localparam logic [7:0] K_CHIP  = 8'h10;
  localparam logic [7:0] K_BLK   = 8'h30;
  localparam logic [7:0] K_SUSP  = 8'hB0;
  localparam logic [7:0] K_BEXIT = 8'h00;

endpackage

// File: rtl/flash_unlock_match.sv
module flash_unlock_match #(
  parameter int CMP_W = 11
) (
  input  logic             byte_mode,
  input  logic [CMP_W-1:0] addr_low,
  input  logic             addr_lsb,
  output logic             at_unl1,
  output logic             at_unl2
);
  localparam int KEY_W = CMP_W + 1;

  // alternating pattern with bit 0 set: 0x555 for 11 bits
  function automatic logic [CMP_W-1:0] alt_pat();
    logic [CMP_W-1:0] p;
    for (int i = 0; i < CMP_W; i++) p[i] = (i % 2 == 0);
    return p;
  endfunction

  localparam logic [CMP_W-1:0] PAT_A = alt_pat();
  localparam logic [CMP_W-1:0] PAT_B = PAT_A >> 1;

  logic [KEY_W-1:0] key;
  logic [KEY_W-1:0] ref1;
  logic [KEY_W-1:0] ref2;

  always_comb begin
    if (byte_mode) begin
      key  = {addr_low, addr_lsb};
      ref1 = {PAT_A, 1'b0};
      ref2 = {PAT_B, 1'b1};
    end else begin
      key  = {1'b0, addr_low};
      ref1 = {1'b0, PAT_A};
      ref2 = {1'b0, PAT_B};
    end
    at_unl1 = (key == ref1);
    at_unl2 = (key == ref2);
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] dat,
  input  logic       at_unl1,
  input  logic       at_unl2,
  input  logic       pgm_active,
  input  logic       ers_active,
  output mode_e      mode,
  output cmd_t       cmd,
  output logic       cap_en
);
  seq_e  seq_q, seq_n;
  mode_e mode_q, mode_n;
  cmd_t  cmd_q, cmd_n;

  always_comb begin
    seq_n  = seq_q;
    mode_n = mode_q;
    cmd_n  = '0;
    cap_en = 1'b0;
    if (mode_q == MODE_ECOL && ers_active) mode_n = MODE_READ;
    if (wr_en && !pgm_active) begin
      if (ers_active) begin
        if (dat == K_RESET) begin
          cmd_n.rst = 1'b1;
          seq_n     = SQ_IDLE;
          mode_n    = (mode_q == MODE_BYP) ? MODE_BYP : MODE_READ;
        end else if (dat == K_SUSP) begin
          cmd_n.susp = 1'b1;
          seq_n      = SQ_IDLE;
        end
      end else if (mode_q == MODE_BYP) begin
        seq_n = SQ_IDLE;
        case (seq_q)
          SQ_BPGM: begin
            cmd_n.pgm = 1'b1;
            cap_en    = 1'b1;
          end
          SQ_BEXIT: begin
            if (dat == K_BEXIT) mode_n = MODE_READ;
          end
          default: begin
            if (dat == K_PGM)        seq_n     = SQ_BPGM;
            else if (dat == K_ASEL)  seq_n     = SQ_BEXIT;
            else if (dat == K_RESET) cmd_n.rst = 1'b1;
          end
        endcase
      end else begin
        seq_n = SQ_IDLE;
        case (seq_q)
          SQ_IDLE: begin
            if (mode_q == MODE_ECOL && dat == K_BLK) begin
              cmd_n.blk = 1'b1;
              cap_en    = 1'b1;
            end else begin
              if (mode_q == MODE_ECOL) mode_n = MODE_READ;
              if (dat == K_UNL_A && at_unl1) begin
                seq_n = SQ_UNL1;
              end else begin
                mode_n = MODE_READ;
                if (dat == K_RESET)     cmd_n.rst    = 1'b1;
                else if (dat == K_SUSP) cmd_n.susp   = 1'b1;
                else if (dat == K_BLK)  cmd_n.resume = 1'b1;
              end
            end
          end
          SQ_UNL1: begin
            if (dat == K_UNL_B && at_unl2) seq_n  = SQ_UNL2;
            else                           mode_n = MODE_READ;
          end
          SQ_UNL2: begin
            mode_n = MODE_READ;
            if (dat == K_RESET)                 cmd_n.rst = 1'b1;
            else if (at_unl1 && dat == K_ASEL)  mode_n    = MODE_ASEL;
            else if (at_unl1 && dat == K_BYP)   mode_n    = MODE_BYP;
            else if (at_unl1 && dat == K_PGM)   seq_n     = SQ_PGM;
            else if (at_unl1 && dat == K_ERASE) seq_n     = SQ_ERS1;
          end
          SQ_PGM: begin
            mode_n    = MODE_READ;
            cmd_n.pgm = 1'b1;
            cap_en    = 1'b1;
          end
          SQ_ERS1: begin
            mode_n = MODE_READ;
            if (dat == K_UNL_A && at_unl1) seq_n = SQ_ERS2;
          end
          SQ_ERS2: begin
            mode_n = MODE_READ;
            if (dat == K_UNL_B && at_unl2) seq_n = SQ_ERS3;
          end
          SQ_ERS3: begin
            mode_n = MODE_READ;
            if (dat == K_CHIP && at_unl1) begin
              cmd_n.chip = 1'b1;
            end else if (dat == K_BLK) begin
              cmd_n.blk = 1'b1;
              cap_en    = 1'b1;
              mode_n    = MODE_ECOL;
            end
          end
          default: mode_n = MODE_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SQ_IDLE;
      mode_q <= MODE_READ;
      cmd_q  <= '0;
    end else begin
      seq_q  <= seq_n;
      mode_q <= mode_n;
      cmd_q  <= cmd_n;
    end
  end

  assign mode = mode_q;
  assign cmd  = cmd_q;
endmodule

// File: rtl/flash_autosel_rd.sv
module flash_autosel_rd #(
  parameter int          ADDR_W   = 17,
  parameter int          DATA_W   = 16,
  parameter int          SEC_W    = 5,
  parameter logic [15:0] MFR_CODE = 16'h0020,
  parameter logic [15:0] DEV_CODE = 16'h0051
) (
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [2**SEC_W-1:0]   prot_map,
  output logic [DATA_W-1:0]     as_data
);
  logic [SEC_W-1:0] sec;
  assign sec = rd_addr[ADDR_W-1 -: SEC_W];

  always_comb begin
    case (rd_addr[1:0])
      2'b00:   as_data = DATA_W'(MFR_CODE);
      2'b01:   as_data = DATA_W'(DEV_CODE);
      2'b10:   as_data = {{(DATA_W-1){1'b0}}, prot_map[sec]};
      default: as_data = '0;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W   = 17,
  parameter int          DATA_W   = 16,
  parameter int          CMP_W    = 11,
  parameter int          SEC_W    = 5,
  parameter logic [15:0] MFR_CODE = 16'h0020,
  parameter logic [15:0] DEV_CODE = 16'h0051
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic                wr_lsb,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                byte_mode,
  input  logic                pgm_active,
  input  logic                ers_active,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [2**SEC_W-1:0] prot_map,
  output logic [1:0]          mode,
  output logic                cmd_reset,
  output logic                cmd_suspend,
  output logic                cmd_resume,
  output logic                cmd_program,
  output logic                cmd_chip_erase,
  output logic                cmd_block_erase,
  output logic [ADDR_W:0]     op_addr,
  output logic [DATA_W-1:0]   op_data,
  output logic [DATA_W-1:0]   as_data
);
  logic  at_unl1, at_unl2, cap_en;
  mode_e mode_w;
  cmd_t  cmd_w;
  logic [ADDR_W:0]   op_addr_q;
  logic [DATA_W-1:0] op_data_q;

  flash_unlock_match #(.CMP_W(CMP_W)) match_i (
    .byte_mode (byte_mode),
    .addr_low  (wr_addr[CMP_W-1:0]),
    .addr_lsb  (wr_lsb),
    .at_unl1   (at_unl1),
    .at_unl2   (at_unl2)
  );

  flash_cmd_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .dat        (wr_data[7:0]),
    .at_unl1    (at_unl1),
    .at_unl2    (at_unl2),
    .pgm_active (pgm_active),
    .ers_active (ers_active),
    .mode       (mode_w),
    .cmd        (cmd_w),
    .cap_en     (cap_en)
  );

  flash_autosel_rd #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W),
    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) asel_i (
    .rd_addr  (rd_addr),
    .prot_map (prot_map),
    .as_data  (as_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr_q <= '0;
      op_data_q <= '0;
    end else if (cap_en) begin
      op_addr_q <= {wr_addr, byte_mode ? wr_lsb : 1'b0};
      op_data_q <= byte_mode ? {{(DATA_W-8){1'b0}}, wr_data[7:0]} : wr_data;
    end
  end

  assign mode            = mode_w;
  assign cmd_reset       = cmd_w.rst;
  assign cmd_suspend     = cmd_w.susp;
  assign cmd_resume      = cmd_w.resume;
  assign cmd_program     = cmd_w.pgm;
  assign cmd_chip_erase  = cmd_w.chip;
  assign cmd_block_erase = cmd_w.blk;
  assign op_addr         = op_addr_q;
  assign op_data         = op_data_q;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int          ADDR_W   = 17,
  parameter int          DATA_W   = 16,
  parameter logic [15:0] MFR_CODE = 16'h0020,
  parameter logic [15:0] DEV_CODE = 16'h0051
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              pgm_active,
  input logic              ers_active,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [1:0]        mode,
  input logic              cmd_reset,
  input logic              cmd_suspend,
  input logic              cmd_resume,
  input logic              cmd_program,
  input logic              cmd_chip_erase,
  input logic              cmd_block_erase,
  input logic [DATA_W-1:0] as_data
);
  logic [5:0] pv;
  assign pv = {cmd_reset, cmd_suspend, cmd_resume, cmd_program, cmd_chip_erase, cmd_block_erase};

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pv)); // R14
  AST_NO_WRITE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> (pv == 6'b0)); // R14
  AST_PGM_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_active && mode != 2'd3) |=> ($stable(mode) && pv == 6'b0)); // R12
  AST_ERS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_active && !pgm_active) |=> !(cmd_program || cmd_chip_erase || cmd_block_erase || cmd_resume)); // R13
  AST_BYP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !(wr_en && wr_data[7:0] == 8'h00)) |=> (mode == 2'd2)); // R10
  AST_ASEL_MFR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[1:0] == 2'b00) |-> (as_data == DATA_W'(MFR_CODE))); // R11
  AST_ASEL_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[1:0] == 2'b01) |-> (as_data == DATA_W'(DEV_CODE))); // R11
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .pgm_active(pgm_active), .ers_active(ers_active), .rd_addr(rd_addr),
  .mode(mode), .cmd_reset(cmd_reset), .cmd_suspend(cmd_suspend),
  .cmd_resume(cmd_resume), .cmd_program(cmd_program),
  .cmd_chip_erase(cmd_chip_erase), .cmd_block_erase(cmd_block_erase),
  .as_data(as_data)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_lsb, byte_mode, pgm_active, ers_active;
  logic [16:0] wr_addr, rd_addr;
  logic [15:0] wr_data;
  logic [31:0] prot_map;
  logic [1:0]  mode;
  logic        cmd_reset, cmd_suspend, cmd_resume, cmd_program, cmd_chip_erase, cmd_block_erase;
  logic [17:0] op_addr;
  logic [15:0] op_data, as_data;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;
  logic [5:0] pv;
  logic [1:0] md;

  always #5 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_lsb(wr_lsb),
    .wr_data(wr_data), .byte_mode(byte_mode), .pgm_active(pgm_active),
    .ers_active(ers_active), .rd_addr(rd_addr), .prot_map(prot_map), .mode(mode),
    .cmd_reset(cmd_reset), .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
    .cmd_program(cmd_program), .cmd_chip_erase(cmd_chip_erase),
    .cmd_block_erase(cmd_block_erase), .op_addr(op_addr), .op_data(op_data),
    .as_data(as_data)
  );

  localparam logic [5:0] P_NONE = 6'b000000, P_RST = 6'b100000, P_SUSP = 6'b010000,
                         P_RES = 6'b001000, P_PGM = 6'b000100, P_CHIP = 6'b000010,
                         P_BLK = 6'b000001;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic l, input logic [15:0] d);
    wr_addr = a; wr_lsb = l; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    pv = {cmd_reset, cmd_suspend, cmd_resume, cmd_program, cmd_chip_erase, cmd_block_erase};
    md = mode;
  endtask

  // write at a 12-bit compare key; upper bits and high data byte are junk
  task automatic wrk(input logic [11:0] key, input logic [7:0] d);
    if (byte_mode) wr({6'h2D, key[11:1]}, key[0], {8'hC3, d});
    else           wr({6'h16, key[10:0]}, 1'b1, {8'h3C, d});
  endtask

  function automatic logic [11:0] u1k();
    return byte_mode ? 12'hAAA : 12'h555;
  endfunction
  function automatic logic [11:0] u2k();
    return byte_mode ? 12'h555 : 12'h2AA;
  endfunction

  task automatic unlock();
    wrk(u1k(), 8'hAA);
    wrk(u2k(), 8'h55);
  endtask

  function automatic logic [7:0] exp3(input logic [7:0] d);
    case (d)
      8'hF0:   return {P_RST, 2'd0};
      8'h90:   return {P_NONE, 2'd1};
      8'h20:   return {P_NONE, 2'd2};
      default: return {P_NONE, 2'd0};
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_lsb = 1'b0; wr_data = '0;
    byte_mode = 1'b0; pgm_active = 1'b0; ers_active = 1'b0; rd_addr = '0;
    prot_map = 32'hA5C3_1E69;
    repeat (3) @(negedge clk);
    chk("R14 reset mode", mode, 0);
    chk("R14 reset pulses", {cmd_reset, cmd_suspend, cmd_resume, cmd_program, cmd_chip_erase, cmd_block_erase}, 0);
    chk("R14 reset op", {op_addr, op_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // third-cycle sweep over all data values, both widths (R1 R2 R3 R4 R9)
    for (int bm = 0; bm < 2; bm++) begin
      byte_mode = bm[0];
      for (int d = 0; d < 256; d++) begin
        wr(17'h0, 1'b0, 16'h00F0);
        unlock();
        wrk(u1k(), d[7:0]);
        chk("R3 third cycle", {pv, md}, exp3(d[7:0]));
        if (d == 8'hA0) begin
          wr(17'h1ABCD, 1'b1, 16'h5A3C);
          chk("R4 program pulse", {pv, md}, {P_PGM, 2'd0});
          chk("R4 program addr", op_addr, {17'h1ABCD, bm[0]});
          chk("R4 program data", op_data, bm[0] ? 16'h003C : 16'h5A3C);
        end else if (d == 8'h20) begin
          wr(17'h0, 1'b0, 16'h0090);
          wr(17'h0, 1'b0, 16'h0000);
          chk("R9 bypass exit", {pv, md}, {P_NONE, 2'd0});
        end
      end
    end
    byte_mode = 1'b0;

    // wrong unlock address in each width (R1)
    for (int bm = 0; bm < 2; bm++) begin
      byte_mode = bm[0];
      wrk(u1k() ^ 12'h004, 8'hAA);
      wrk(u2k(), 8'h55);
      wrk(u1k(), 8'h90);
      chk("R1 wrong unlock address", md, 0);
    end
    byte_mode = 1'b0;

    // single-write commands (R7)
    wr(17'h1F0F0, 1'b0, 16'h00F0); chk("R7 reset", pv, P_RST);
    wr(17'h00123, 1'b0, 16'h77B0); chk("R7 suspend", pv, P_SUSP);
    wr(17'h0F00F, 1'b1, 16'h0030); chk("R7 resume", pv, P_RES);

    // broken sequences (R8)
    wrk(12'h555, 8'hAA);
    wrk(12'h2AB, 8'h55);
    chk("R8 break pulse", {pv, md}, {P_NONE, 2'd0});
    wrk(12'h555, 8'hA0);
    wr(17'h00100, 1'b0, 16'h1234);
    chk("R8 no program after break", pv, P_NONE);
    unlock(); wrk(12'h555, 8'h90);
    chk("R3 identification entry", md, 1);
    wr(17'h0, 1'b0, 16'h0012);
    chk("R8 break leaves identification", md, 0);

    // chip erase (R5)
    unlock(); wrk(12'h555, 8'h80); unlock(); wrk(12'h556, 8'h10);
    chk("R5 chip erase wrong address", {pv, md}, {P_NONE, 2'd0});
    unlock(); wrk(12'h555, 8'h80); unlock(); wrk(12'h555, 8'h10);
    chk("R5 chip erase", {pv, md}, {P_CHIP, 2'd0});

    // block erase and block collection (R6)
    unlock(); wrk(12'h555, 8'h80); unlock();
    wr(17'h18000, 1'b0, 16'h0030);
    chk("R6 block erase", {pv, md}, {P_BLK, 2'd3});
    chk("R6 block addr", op_addr, {17'h18000, 1'b0});
    wr(17'h04321, 1'b0, 16'hFF30);
    chk("R6 added block", {pv, md}, {P_BLK, 2'd3});
    chk("R6 added addr", op_addr, {17'h04321, 1'b0});
    ers_active = 1'b1;
    @(negedge clk);
    chk("R6 collection ends on erase start", mode, 0);
    wr(17'h02000, 1'b0, 16'h0030); chk("R13 block ignored while erasing", {pv, md}, {P_NONE, 2'd0});
    wr(17'h00000, 1'b0, 16'h0010); chk("R13 other ignored while erasing", pv, P_NONE);
    wr(17'h00000, 1'b0, 16'h00B0); chk("R13 suspend while erasing", pv, P_SUSP);
    wr(17'h00000, 1'b0, 16'h00F0); chk("R13 reset while erasing", pv, P_RST);
    ers_active = 1'b0;

    // non-30 write ends collection (R6)
    unlock(); wrk(12'h555, 8'h80); unlock();
    wr(17'h08000, 1'b0, 16'h0030);
    wr(17'h08000, 1'b0, 16'h0011);
    chk("R6 collection ends on other write", {pv, md}, {P_NONE, 2'd0});

    // program busy (R12)
    unlock(); wrk(12'h555, 8'h90);
    pgm_active = 1'b1;
    wr(17'h0, 1'b0, 16'h00F0); chk("R12 reset ignored", {pv, md}, {P_NONE, 2'd1});
    wr(17'h0, 1'b0, 16'h00B0); chk("R12 suspend ignored", {pv, md}, {P_NONE, 2'd1});
    wr(17'h0, 1'b0, 16'h0030); chk("R12 resume ignored", {pv, md}, {P_NONE, 2'd1});
    pgm_active = 1'b0;
    wr(17'h0, 1'b0, 16'h00F0); chk("R12 accepted after busy", {pv, md}, {P_RST, 2'd0});

    // bypass mode (R9 R10)
    unlock(); wrk(12'h555, 8'h20);
    chk("R9 bypass entry", md, 2);
    unlock(); chk("R9 unlock rejected in bypass", {pv, md}, {P_NONE, 2'd2});
    wr(17'h0, 1'b0, 16'h0030); chk("R9 resume rejected in bypass", {pv, md}, {P_NONE, 2'd2});
    wr(17'h0, 1'b0, 16'h00A0);
    wr(17'h0ACE1, 1'b0, 16'hBEEF);
    chk("R9 bypass program", {pv, md}, {P_PGM, 2'd2});
    chk("R9 bypass program addr", op_addr, {17'h0ACE1, 1'b0});
    chk("R9 bypass program data", op_data, 16'hBEEF);
    wr(17'h0, 1'b0, 16'h00F0); chk("R10 reset keeps bypass", {pv, md}, {P_RST, 2'd2});
    ers_active = 1'b1;
    wr(17'h0, 1'b0, 16'h00F0); chk("R10 reset keeps bypass while erasing", {pv, md}, {P_RST, 2'd2});
    ers_active = 1'b0;
    wr(17'h0, 1'b0, 16'h0090);
    wr(17'h0, 1'b0, 16'h0012);
    chk("R9 bad exit stays", md, 2);
    wr(17'h0, 1'b0, 16'h0090);
    wr(17'h0, 1'b0, 16'h0000);
    chk("R9 exit", md, 0);

    // identification read sweep (R11)
    for (int s = 0; s < 32; s++) begin
      for (int lo = 0; lo < 4; lo++) begin
        logic [15:0] e;
        rd_addr = {s[4:0], 10'h2B5, lo[1:0]};
        #1;
        case (lo)
          0: e = 16'h0020;
          1: e = 16'h0051;
          2: e = {15'b0, prot_map[s]};
          default: e = 16'h0000;
        endcase
        chk("R11 identification read", as_data, e);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule